// File: doc/BRIEF.md
# Output Narrowing Stage for a Decimating Integrator-Comb Filter

This block takes the wide, full-precision result of an integrator-comb decimation or interpolation filter and reduces it to a narrower signed output word. It removes a fixed number of low-order bits, using a reduction mode chosen at run time. It also limits the remaining high-order bits to the output width. This lets a filter whose internal growth is large feed a narrow downstream datapath. The designer picks how quantisation error is shaped and whether an out-of-range value wraps or clamps.

The input width, the number of discarded low bits and the output width are elaboration parameters. The output width may be any value from 1 bit up to the width left after the low bits are removed. The mode can change from one sample to the next. Each accepted sample comes out exactly one clock later with its valid flag. The output register keeps its last value while no sample is accepted.

Top module: `cic_narrow`

## Requirements
- R1: After reset, `valid_o` is 0 and `data_o` is all zeros.
- R2: Mode code 0 (truncate) gives floor(x / 2^DROP_W), with the discarded bits simply removed.
- R3: Mode code 1 (convergent) rounds x / 2^DROP_W to nearest. An exact half goes to the neighbouring even integer.
- R4: Mode code 2 (half-up) gives floor(x / 2^DROP_W + 1/2). An exact half goes toward positive infinity.
- R5: Mode code 3 (saturate) rounds as in R4, then clamps the result into [-2^(OUT_W-1), 2^(OUT_W-1)-1]. This includes a value pushed out of range by the rounding carry.
- R6: In mode codes 0, 1 and 2, a result outside the output range wraps: `data_o` holds its low OUT_W bits in two's complement.
- R7: With DROP_W = 0, mode codes 0, 1 and 2 present the low OUT_W bits of the input unchanged. When OUT_W equals IN_W, mode code 3 does so too.
- R8: `valid_o` equals `valid_i` from one clock earlier. A sample accepted at one rising edge appears on `data_o` right after that edge.
- R9: A cycle with `valid_i` low leaves `data_o` unchanged, whatever `data_i` and `mode_i` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample present this cycle |
| mode_i | input | 2 | Reduction mode: 0 truncate, 1 convergent, 2 half-up, 3 saturate |
| data_i | input | IN_W | Full-precision signed input word |
| valid_o | output | 1 | Output sample present |
| data_o | output | OUT_W | Narrowed signed output word |

## Verification
Every input code of an 8-bit word is swept through each of the four modes with three discarded bits and a 4-bit output. The sweep therefore covers every fractional pattern: below half, exactly half with both odd and even kept values, and above half. It also covers values that overflow the output range with and without a rounding carry. Exact halves distinguish convergent from half-up rounding. The values near both range ends distinguish clamping from wrapping and reveal a lost carry. A second instance with no discarded bits is swept through every mode to show the data passes unchanged. Short directed sequences then toggle the valid flag with changing data to confirm the one-cycle latency and that the output holds.

// File: rtl/cic_narrow_pkg.sv
package cic_narrow_pkg;

    typedef enum logic [1:0] {
        NARROW_TRUNC  = 2'd0,
        NARROW_CONV   = 2'd1,
        NARROW_HALFUP = 2'd2,
        NARROW_SAT    = 2'd3
    } narrow_mode_e;

endpackage

// File: rtl/cic_round_unit.sv
module cic_round_unit
    import cic_narrow_pkg::*;
#(
    parameter int IN_W   = 8,
    parameter int DROP_W = 3,
    localparam int KW    = IN_W - DROP_W,
    localparam int RW    = KW + 1
) (
    input  logic [IN_W-1:0]     x_i,
    input  narrow_mode_e        mode_i,
    output logic signed [RW-1:0] y_o
);

    logic [KW-1:0] floor_w;
    logic          half_w;
    logic          sticky_w;
    logic          inc_w;

    // kept bits form the arithmetic floor of x / 2^DROP_W
    assign floor_w = x_i[IN_W-1:DROP_W];

    generate
        if (DROP_W == 0) begin : g_nodrop
            assign half_w   = 1'b0;
            assign sticky_w = 1'b0;
        end else begin : g_drop
            assign half_w = x_i[DROP_W-1];
            if (DROP_W > 1) begin : g_sticky
                assign sticky_w = |x_i[DROP_W-2:0];
            end else begin : g_nosticky
                assign sticky_w = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        unique case (mode_i)
            NARROW_TRUNC: inc_w = 1'b0;
            NARROW_CONV:  inc_w = half_w & (sticky_w | floor_w[0]);
            default:      inc_w = half_w;
        endcase
    end

    // one guard bit keeps the rounding carry visible to the limiter
    assign y_o = $signed({floor_w[KW-1], floor_w} + RW'(inc_w));

endmodule

// File: rtl/cic_range_limit.sv
module cic_range_limit #(
    parameter int RW    = 6,
    parameter int OUT_W = 4
) (
    input  logic signed [RW-1:0] v_i,
    input  logic                 sat_i,
    output logic [OUT_W-1:0]     y_o
);

    localparam logic signed [RW-1:0] HI_V = RW'((longint'(1) <<< (OUT_W - 1)) - 1);
    localparam logic signed [RW-1:0] LO_V = RW'(-(longint'(1) <<< (OUT_W - 1)));

    always_comb begin
        if (sat_i && (v_i > HI_V)) begin
            y_o = HI_V[OUT_W-1:0];
        end else if (sat_i && (v_i < LO_V)) begin
            y_o = LO_V[OUT_W-1:0];
        end else begin
            y_o = v_i[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/cic_narrow.sv
module cic_narrow
    import cic_narrow_pkg::*;
#(
    parameter int IN_W   = 8,
    parameter int OUT_W  = 4,
    parameter int DROP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [1:0]        mode_i,
    input  logic [IN_W-1:0]   data_i,
    output logic              valid_o,
    output logic [OUT_W-1:0]  data_o
);

    localparam int KW = IN_W - DROP_W;
    localparam int RW = KW + 1;
    localparam logic signed [RW-1:0] HI_T = RW'((longint'(1) <<< (OUT_W - 1)) - 1);
    localparam logic signed [RW-1:0] LO_T = RW'(-(longint'(1) <<< (OUT_W - 1)));

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] data;
    } stage_t;

    narrow_mode_e        mode_w;
    logic signed [RW-1:0] rnd_w;
    logic [OUT_W-1:0]    lim_w;
    stage_t              st_d, st_q;

    assign mode_w = narrow_mode_e'(mode_i);

    cic_round_unit #(
        .IN_W   (IN_W),
        .DROP_W (DROP_W)
    ) u_round (
        .x_i    (data_i),
        .mode_i (mode_w),
        .y_o    (rnd_w)
    );

    cic_range_limit #(
        .RW    (RW),
        .OUT_W (OUT_W)
    ) u_limit (
        .v_i   (rnd_w),
        .sat_i (mode_w == NARROW_SAT),
        .y_o   (lim_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.data = lim_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;

    // ---------------- assertions ----------------
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    logic [OUT_W-1:0] floor_ref_w;
    assign floor_ref_w = data_i[DROP_W+OUT_W-1:DROP_W];

    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (valid_o == 1'b0));

    p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_w == NARROW_TRUNC) |=> (data_o == $past(floor_ref_w)));

    p_clamp_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_w == NARROW_SAT && rnd_w > HI_T) |=> (data_o == HI_T[OUT_W-1:0]));

    p_clamp_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_w == NARROW_SAT && rnd_w < LO_T) |=> (data_o == LO_T[OUT_W-1:0]));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_w != NARROW_SAT) |=> (data_o == $past(rnd_w[OUT_W-1:0])));

    generate
        if (DROP_W == 0) begin : g_pass_chk
            p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_i && mode_w != NARROW_SAT) |=> (data_o == $past(data_i[OUT_W-1:0])));
        end
    endgenerate

    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (valid_o == $past(valid_i)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(data_o));

endmodule

// File: tb/cic_narrow_test.sv
module cic_narrow_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [7:0] data_a = '0;
    logic [5:0] data_b = '0;
    logic       valid_a, valid_b;
    logic [3:0] out_a;
    logic [5:0] out_b;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cic_narrow #(.IN_W(8), .OUT_W(4), .DROP_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
        .data_i(data_a), .valid_o(valid_a), .data_o(out_a));

    cic_narrow #(.IN_W(6), .OUT_W(6), .DROP_W(0)) uut_z (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
        .data_i(data_b), .valid_o(valid_b), .data_o(out_b));

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // integer reference: returns the unwrapped result
    function automatic int ref_val(input int x, input int mode, input int drop, input int outw);
        int fl, frac, half, y, hi, lo;
        fl   = x >>> drop;
        frac = x - fl * (1 << drop);
        half = (drop == 0) ? 0 : (1 << (drop - 1));
        y    = fl;
        if (drop > 0) begin
            case (mode)
                1: if (frac > half || (frac == half && (fl % 2 != 0))) y = fl + 1;
                2, 3: if (frac >= half) y = fl + 1;
                default: y = fl;
            endcase
        end
        if (mode == 3) begin
            hi = (1 << (outw - 1)) - 1;
            lo = -(1 << (outw - 1));
            if (y > hi) y = hi;
            if (y < lo) y = lo;
        end
        return y & ((1 << outw) - 1);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", int'(valid_a), 0);
        check("R1 data", int'(out_a), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep(input int mode, input string req);
        for (int v = -128; v < 128; v++) begin
            @(negedge clk);
            valid_i = 1'b1;
            mode_i  = 2'(mode);
            data_a  = 8'(v);
            @(posedge clk);
            #1;
            check(req, int'(out_a), ref_val(v, mode, 3, 4));
        end
        check("R8 valid after sweep", int'(valid_a), 1);
    endtask

    task automatic t_zero_drop();
        for (int m = 0; m < 4; m++) begin
            for (int v = -32; v < 32; v++) begin
                @(negedge clk);
                valid_i = 1'b1;
                mode_i  = 2'(m);
                data_b  = 6'(v);
                @(posedge clk);
                #1;
                check("R7 passthrough", int'(out_b), v & 63);
            end
        end
    endtask

    task automatic t_valid_hold();
        @(negedge clk);
        valid_i = 1'b1; mode_i = 2'd2; data_a = 8'sd44;   // 44/8=5.5 -> 6
        @(posedge clk); #1;
        check("R8 valid high", int'(valid_a), 1);
        check("R4 half-up 5.5", int'(out_a), 6);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            valid_i = 1'b0; mode_i = 2'(k); data_a = 8'(k * 37 - 90);
            @(posedge clk); #1;
            check("R8 valid low", int'(valid_a), 0);
            check("R9 hold", int'(out_a), 6);
        end
        @(negedge clk);
        valid_i = 1'b1; mode_i = 2'd1; data_a = 8'sd44;   // even neighbour 6
        @(posedge clk); #1;
        check("R3 half to even", int'(out_a), 6);
        @(negedge clk);
        data_a = 8'sd36;                                   // 4.5 -> 4
        @(posedge clk); #1;
        check("R3 half to even low", int'(out_a), 4);
        @(negedge clk);
        mode_i = 2'd3; data_a = 8'sd63;                    // 7.875 -> 8 clamps to 7
        @(posedge clk); #1;
        check("R5 carry clamp", int'(out_a), 7);
        @(negedge clk);
        mode_i = 2'd2;                                     // 8 wraps to -8
        @(posedge clk); #1;
        check("R6 carry wrap", int'(out_a), 8);
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_sweep(0, "R2 R6 truncate");
        t_sweep(1, "R3 R6 convergent");
        t_sweep(2, "R4 R6 half-up");
        t_sweep(3, "R5 saturate");
        t_zero_drop();
        t_valid_hold();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule